// File: doc/BRIEF.md
# Pulse-Width Sensor Responder

This block plays the device side of a single-wire humidity and temperature sensor link. A host shares one open-drain data line with it. The line reads high unless one side pulls it low. The host asks for a reading by holding the line low and then letting it go. The responder reacts to that release. It waits briefly and then answers with a low-then-high acknowledge. After that it sends a 40-bit frame. Every bit starts with a fixed low pulse. The length of the high phase that follows gives the bit value. A final low pulse closes the frame, and the line is then left released.

The frame carries a 32-bit payload word and an 8-bit checksum that the block computes itself. The payload is captured when a request is accepted, so the surrounding logic may change it at any time. All phase lengths are parameters counted in clock cycles. The defaults assume a 100 MHz clock: a 13 us delay, 83 us and 87 us acknowledge phases, 54 us bit-low and trailer pulses, 71 us for a one and 24 us for a zero. The request qualifier rejects short glitches on the line.

Top module: `sensor_pulse_responder`

## Requirements
- R1: A request is accepted when the synchronized line rises after it has been low for at least MIN_START_CYC cycles (MIN_START_CYC must be at least 3). If the host releases the line before clock edge E1, busy_o is high after edge E3 and low after E2.
- R2: On acceptance the responder first leaves the line released for DELAY_CYC cycles.
- R3: The acknowledge then pulls low for ACK_LOW_CYC cycles, then releases for ACK_HIGH_CYC cycles. Every phase keeps its state until its timer expires.
- R4: Each data bit begins with pull_low_o high for BIT_LOW_CYC cycles.
- R5: After the low pulse of a bit, the line is released for ONE_HIGH_CYC cycles when the bit is 1 and for ZERO_HIGH_CYC cycles when it is 0.
- R6: The frame is 40 bits, sent most significant bit first. Bits 39..8 are payload_i[31:0] and bits 7..0 are the checksum.
- R7: The checksum is the sum of the four payload bytes, truncated to 8 bits.
- R8: After the 40th bit, pull_low_o is high for TAIL_LOW_CYC cycles. busy_o and pull_low_o then fall on the same edge.
- R9: Changes on payload_i after acceptance do not alter the frame in progress.
- R10: busy_o stays high from acceptance until the trailer ends. Line activity during that time starts no new transaction.
- R11: A low period shorter than MIN_START_CYC cycles followed by a rise is ignored.
- R12: During and right after reset, pull_low_o and busy_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_in | input | 1 | Level currently read on the shared data line |
| payload_i | input | 32 | Payload word captured when a request is accepted |
| pull_low_o | output | 1 | 1 enables the open-drain driver to pull the line low |
| busy_o | output | 1 | High while a transaction is in progress |

## Verification
The frame path is tried with four payloads. 0x33005500 has a small checksum with no carry. 0xFFFFFFFF makes the byte sum wrap, which tells truncation apart from a wider sum. All zeros gives a frame of short high phases only. 0xA50F3CC1 has mixed bit runs, which exposes a swapped bit order or a swapped one/zero width. The request qualifier is tried with a low period one cycle shorter than the minimum and with one of exactly the minimum, which locates the accept threshold. Other frames change the payload input after acceptance, or pulse the line during a frame, to show that neither reaches the transaction in progress.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

    localparam int unsigned PAYLOAD_W = 32;
    localparam int unsigned CSUM_W    = 8;
    localparam int unsigned FRAME_W   = PAYLOAD_W + CSUM_W;
    localparam int unsigned BIT_IDX_W = $clog2(FRAME_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DELAY,
        ST_ACK_LOW,
        ST_ACK_HIGH,
        ST_BIT_LOW,
        ST_BIT_HIGH,
        ST_TAIL_LOW
    } phase_e;

    typedef struct packed {
        logic [PAYLOAD_W-1:0] payload;
        logic [CSUM_W-1:0]    csum;
    } frame_t;

    function automatic logic [CSUM_W-1:0] byte_sum(input logic [PAYLOAD_W-1:0] w);
        logic [CSUM_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < PAYLOAD_W / CSUM_W; i++) begin
            acc = acc + w[i*CSUM_W +: CSUM_W];
        end
        return acc;
    endfunction

    function automatic frame_t build_frame(input logic [PAYLOAD_W-1:0] w);
        frame_t f;
        f.payload = w;
        f.csum    = byte_sum(w);
        return f;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rsp_line_sync.sv
module rsp_line_sync #(
    parameter int unsigned MIN_LOW_CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    input  logic armed_i,
    output logic start_ok_o
);
    localparam int unsigned LW = $clog2(MIN_LOW_CYC + 1);

    logic          s1_q, s2_q, prev_q;
    logic [LW-1:0] low_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b1;
            s2_q   <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            s1_q   <= line_i;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    // Saturating low-duration counter, cleared while a transaction runs.
    always_ff @(posedge clk) begin
        if (rst) begin
            low_q <= '0;
        end else if (!armed_i || s2_q) begin
            low_q <= '0;
        end else if (low_q != LW'(MIN_LOW_CYC)) begin
            low_q <= low_q + 1'b1;
        end
    end

    assign start_ok_o = armed_i && s2_q && !prev_q && (low_q == LW'(MIN_LOW_CYC));

endmodule

// File: rtl/rsp_phase_timer.sv
module rsp_phase_timer #(
    parameter int unsigned CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    // R3: an expired timer stays expired until the next phase reloads it
    assert_timer_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !load_i) |=> (cnt_q == '0));

endmodule

// File: rtl/rsp_frame_shreg.sv
module rsp_frame_shreg
    import rsp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_i,
    input  logic                 shift_i,
    input  logic [PAYLOAD_W-1:0] payload_i,
    output logic                 msb_o
);
    frame_t frame_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
        end else if (load_i) begin
            frame_q <= build_frame(payload_i);
        end else if (shift_i) begin
            frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
        end
    end

    assign msb_o = frame_q[FRAME_W-1];

    // R9: the captured frame only changes on capture or shift, never from the input
    assert_frame_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !shift_i) |=> $stable(frame_q));

endmodule

// File: rtl/sensor_pulse_responder.sv
module sensor_pulse_responder
    import rsp_pkg::*;
#(
    parameter int unsigned DELAY_CYC     = 1300,
    parameter int unsigned ACK_LOW_CYC   = 8300,
    parameter int unsigned ACK_HIGH_CYC  = 8700,
    parameter int unsigned BIT_LOW_CYC   = 5400,
    parameter int unsigned ONE_HIGH_CYC  = 7100,
    parameter int unsigned ZERO_HIGH_CYC = 2400,
    parameter int unsigned TAIL_LOW_CYC  = 5400,
    parameter int unsigned MIN_START_CYC = 1000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 line_in,
    input  logic [PAYLOAD_W-1:0] payload_i,
    output logic                 pull_low_o,
    output logic                 busy_o
);
    localparam int unsigned MAX_A = max2(max2(DELAY_CYC, ACK_LOW_CYC), max2(ACK_HIGH_CYC, BIT_LOW_CYC));
    localparam int unsigned MAX_B = max2(max2(ONE_HIGH_CYC, ZERO_HIGH_CYC), TAIL_LOW_CYC);
    localparam int unsigned CNT_W = $clog2(max2(MAX_A, MAX_B) + 1);

    phase_e               state_q, state_d;
    logic [BIT_IDX_W-1:0] bit_q;
    logic                 start_ok, tmr_zero, tmr_load, cap, shf, bit_inc, cur_bit;
    logic [CNT_W-1:0]     tmr_val;

    rsp_line_sync #(.MIN_LOW_CYC(MIN_START_CYC)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .line_i    (line_in),
        .armed_i   (state_q == ST_IDLE),
        .start_ok_o(start_ok)
    );

    rsp_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .zero_o    (tmr_zero)
    );

    rsp_frame_shreg u_frame (
        .clk      (clk),
        .rst      (rst),
        .load_i   (cap),
        .shift_i  (shf),
        .payload_i(payload_i),
        .msb_o    (cur_bit)
    );

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap      = 1'b0;
        shf      = 1'b0;
        bit_inc  = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start_ok) begin
                state_d  = ST_DELAY;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(DELAY_CYC - 1);
                cap      = 1'b1;
            end
            ST_DELAY: if (tmr_zero) begin
                state_d  = ST_ACK_LOW;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(ACK_LOW_CYC - 1);
            end
            ST_ACK_LOW: if (tmr_zero) begin
                state_d  = ST_ACK_HIGH;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(ACK_HIGH_CYC - 1);
            end
            ST_ACK_HIGH: if (tmr_zero) begin
                state_d  = ST_BIT_LOW;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(BIT_LOW_CYC - 1);
            end
            ST_BIT_LOW: if (tmr_zero) begin
                state_d  = ST_BIT_HIGH;
                tmr_load = 1'b1;
                tmr_val  = cur_bit ? CNT_W'(ONE_HIGH_CYC - 1) : CNT_W'(ZERO_HIGH_CYC - 1);
            end
            ST_BIT_HIGH: if (tmr_zero) begin
                shf      = 1'b1;
                tmr_load = 1'b1;
                if (bit_q == BIT_IDX_W'(FRAME_W - 1)) begin
                    state_d = ST_TAIL_LOW;
                    tmr_val = CNT_W'(TAIL_LOW_CYC - 1);
                end else begin
                    state_d = ST_BIT_LOW;
                    tmr_val = CNT_W'(BIT_LOW_CYC - 1);
                    bit_inc = 1'b1;
                end
            end
            ST_TAIL_LOW: if (tmr_zero) begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            if (cap)          bit_q <= '0;
            else if (bit_inc) bit_q <= bit_q + 1'b1;
        end
    end

    assign busy_o     = (state_q != ST_IDLE);
    assign pull_low_o = (state_q == ST_ACK_LOW) || (state_q == ST_BIT_LOW) ||
                        (state_q == ST_TAIL_LOW);

    // R1: busy only rises after the qualifier has accepted a request
    assert_accept_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_ok));

    // R2: the first busy cycle leaves the line released
    assert_delay_first_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> !pull_low_o);

    // R3: a phase never moves on while its timer is still running
    assert_phase_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && !tmr_zero) |=> $stable(state_q));

    // R6: the bit index never passes the last frame bit
    assert_bit_range_R6: assert property (@(posedge clk) disable iff (rst)
        bit_q <= BIT_IDX_W'(FRAME_W - 1));

    // R8: when busy falls the line is already released
    assert_tail_release_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> !pull_low_o);

    // R10: a transaction only ends from the trailer phase
    assert_busy_until_tail_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> $past(state_q == ST_TAIL_LOW));

endmodule

// File: tb/sim_sensor_pulse_responder.sv
`timescale 1ns/1ps
module sim_sensor_pulse_responder;

    localparam int DLY = 6, ALO = 10, AHI = 11, BLO = 5, ONE = 9, ZER = 3, TLO = 7, MINS = 8;

    typedef struct {
        bit    lvl;
        int    len;
        string tag;
    } seg_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_low = 1'b0;
    logic [31:0] payload = '0;
    logic        pull_low, busy;
    wire         line = ~pull_low & ~host_low;

    int   n_cmp = 0, n_bad = 0, cyc = 0;
    seg_t expq[$];

    always #10 clk = ~clk;

    sensor_pulse_responder #(
        .DELAY_CYC(DLY), .ACK_LOW_CYC(ALO), .ACK_HIGH_CYC(AHI), .BIT_LOW_CYC(BLO),
        .ONE_HIGH_CYC(ONE), .ZERO_HIGH_CYC(ZER), .TAIL_LOW_CYC(TLO), .MIN_START_CYC(MINS)
    ) u0 (
        .clk(clk), .rst(rst), .line_in(line), .payload_i(payload),
        .pull_low_o(pull_low), .busy_o(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input bit lvl, input int len, input string tag);
        seg_t s;
        s.lvl = lvl; s.len = len; s.tag = tag;
        expq.push_back(s);
    endtask

    // Monitor: measures run lengths of pull_low while busy and pops expectations.
    bit mon_busy = 1'b0, mon_lvl = 1'b0;
    int mon_len = 0;

    task automatic close_run();
        seg_t s;
        if (expq.size() == 0) begin
            check("R10 unexpected segment", mon_len, 0);
        end else begin
            s = expq.pop_front();
            check({s.tag, " level"}, int'(mon_lvl), int'(s.lvl));
            check({s.tag, " length"}, mon_len, s.len);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (busy && !mon_busy) begin
                mon_lvl = pull_low; mon_len = 1;
            end else if (busy) begin
                if (pull_low == mon_lvl) mon_len++;
                else begin
                    close_run();
                    mon_lvl = pull_low; mon_len = 1;
                end
            end else if (mon_busy) begin
                close_run();
            end
            mon_busy = busy;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic host_pulse(input int n);
        host_low = 1'b1;
        repeat (n) @(negedge clk);
        host_low = 1'b0;
    endtask

    // Driver: pushes the expected segments, then issues a request.
    task automatic send_frame(input logic [31:0] w, input int low_len,
                              input bit change_pl, input bit glitch);
        logic [7:0]  cs;
        logic [39:0] fr;
        string       extra;
        bit          seen;
        cs = 8'(w[7:0] + w[15:8] + w[23:16] + w[31:24]);
        fr = {w, cs};
        extra = change_pl ? " R9" : "";
        push(1'b0, DLY, "R2 delay");
        push(1'b1, ALO, "R3 ack low");
        push(1'b0, AHI, "R3 ack high");
        for (int i = 39; i >= 0; i--) begin
            push(1'b1, BLO, "R4 bit low");
            push(1'b0, fr[i] ? ONE : ZER,
                 $sformatf("%s bit%0d%s", (i < 8) ? "R5 R7 csum" : "R5 R6 payload", i, extra));
        end
        push(1'b1, TLO, "R8 trailer");
        payload = w;
        host_pulse(low_len);
        repeat (2) @(negedge clk);
        check("R1 busy before accept edge", int'(busy), 0);
        @(negedge clk);
        check("R1 busy after accept edge", int'(busy), 1);
        if (change_pl) payload = ~w;
        if (glitch) begin
            repeat (100) @(negedge clk);
            host_pulse(MINS + 4);
        end
        while (busy) @(negedge clk);
        seen = 1'b0;
        repeat (25) begin
            @(negedge clk);
            if (busy) seen = 1'b1;
        end
        check("R10 no restart after frame", int'(seen), 0);
    endtask

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        check("R12 pull_low in reset", int'(pull_low), 0);
        check("R12 busy in reset", int'(busy), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R12 pull_low after reset", int'(pull_low), 0);
        check("R12 busy after reset", int'(busy), 0);

        // R11: one cycle short of the minimum is rejected
        host_pulse(MINS - 1);
        seen = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (busy || pull_low) seen = 1'b1;
        end
        check("R11 short low ignored", int'(seen), 0);

        send_frame(32'h3300_5500, MINS, 1'b0, 1'b0);   // exact minimum accepted (R1)
        send_frame(32'hFFFF_FFFF, MINS + 5, 1'b1, 1'b0); // checksum wraps (R7), payload change (R9)
        send_frame(32'h0000_0000, MINS + 2, 1'b0, 1'b1); // line pulsed mid-frame (R10)
        send_frame(32'hA50F_3CC1, MINS + 20, 1'b1, 1'b1);

        check("R10 expectation queue drained", expq.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule